// File: doc/BRIEF.md
# Sync Polarity and Video Mode Classifier

This block watches a separate horizontal and vertical TTL sync pair coming from a computer video source. It measures both against the local clock. From the measurements it decides the active polarity of each sync and whether horizontal activity is present. It also decides whether the line rate is above or below a frequency threshold near 28 kHz, which has a hysteresis band around it. From these results it reports one of three standard 640-wide display modes (480, 400 or 350 visible lines), a low-frequency condition, or no mode. The outputs are a one-hot flag vector and a separate no-signal flag.

The block also regenerates both syncs with the pulse always high-going. The deflection oscillators downstream therefore never need to know what polarity the source used. Every threshold and timeout is given in clock cycles through a parameter. A chip integrator derives these counts from the clock frequency. With a 50 MHz clock, the defaults give a threshold near 28 kHz with about 1 kHz of hysteresis and a line-loss timeout of 100 us.

Top module: `sync_mode_classifier`

## Requirements
- R1: With the line rate judged fast and both syncs decided negative, `mode_oh` reads 4'b0001 (480-line mode).
- R2: With the line rate judged fast, horizontal negative and vertical positive, `mode_oh` reads 4'b0010 (400-line mode).
- R3: With the line rate judged fast, horizontal positive and vertical negative, `mode_oh` reads 4'b0100 (350-line mode).
- R4: With the line rate judged fast and both syncs positive, `mode_oh` reads 4'b0000.
- R5: A line period of at least `H_SLOW_MIN` cycles makes the line rate slow; `mode_oh` then reads 4'b1000, whatever the polarities are.
- R6: A line period of at most `H_FAST_MAX` cycles makes the line rate fast. A period strictly between the two limits leaves the previous fast or slow judgement unchanged.
- R7: While no vertical rising edge arrives within `V_LOST_CYC` cycles (for example, a composite sync on the horizontal pin only), no line-count flag (bits 2..0) is set.
- R8: `no_signal` is 1 out of reset and whenever no horizontal rising edge has arrived for `H_LOST_CYC` cycles. While it is 1, `mode_oh` is 4'b0000.
- R9: `hsync_out` and `vsync_out` carry the input waveform with its pulse high-going, 3 clock cycles after the input.
- R10: The polarity of a sync is negative when its high level lasts at least half of the rising-edge-to-rising-edge period. It takes effect only after `POL_RUNS` consecutive periods agree.
- R11: `mode_oh` has at most one bit set. It changes, other than when cleared by R8, only after two consecutive line measurements give the same class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal TTL sync, either polarity, asynchronous |
| vsync_in | input | 1 | Vertical TTL sync, either polarity, asynchronous |
| mode_oh | output | 4 | bit0 480-line, bit1 400-line, bit2 350-line, bit3 low frequency |
| no_signal | output | 1 | Horizontal activity absent |
| hsync_out | output | 1 | Horizontal sync with high-going pulse |
| vsync_out | output | 1 | Vertical sync with high-going pulse |

## Verification
The bench builds the block with a 12-bit counter, line periods of 40 to 60 cycles, a fast limit of 45 and a slow limit of 50 cycles. It uses a 64-cycle line-loss timeout, a 1000-cycle vertical-loss timeout and three agreeing periods for a polarity decision. At these sizes, every polarity pair and the low-rate case can each be reached within a few thousand cycles. The same holds for both sides of the hysteresis band, the missing-vertical case and the line-loss timeout. The exact measurement at which a mode appears after the line sync resumes can also be observed.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_L480,
        CLS_L400,
        CLS_L350,
        CLS_SLOW
    } cls_e;

    // Class from one measurement; slow rate has precedence over polarity.
    function automatic cls_e classify(
        input logic fast_ok,
        input logic fast,
        input logic h_ok,
        input logic h_neg,
        input logic v_ok,
        input logic v_neg
    );
        cls_e c;
        c = CLS_NONE;
        if (fast_ok && h_ok) begin
            if (!fast) begin
                c = CLS_SLOW;
            end else if (v_ok) begin
                case ({h_neg, v_neg})
                    2'b11:   c = CLS_L480;
                    2'b10:   c = CLS_L400;
                    2'b01:   c = CLS_L350;
                    default: c = CLS_NONE;
                endcase
            end
        end
        return c;
    endfunction

    function automatic logic [3:0] cls_onehot(input cls_e c);
        logic [3:0] v;
        case (c)
            CLS_L480: v = 4'b0001;
            CLS_L400: v = 4'b0010;
            CLS_L350: v = 4'b0100;
            CLS_SLOW: v = 4'b1000;
            default:  v = 4'b0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/smc_sync_meter.sv
module smc_sync_meter #(
    parameter int CNT_W    = 22,
    parameter int LOST_CYC = 5000,
    parameter int POL_RUNS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic             level_pos,
    output logic             active,
    output logic             pol_valid,
    output logic             pol_neg,
    output logic             rise_stb,
    output logic             per_stb,
    output logic [CNT_W-1:0] period
);
    localparam int RUN_W = $clog2(POL_RUNS + 1);
    localparam logic [RUN_W-1:0] RUNS_L   = RUN_W'(POL_RUNS);
    localparam logic [CNT_W-1:0] LOST_LIM = CNT_W'(LOST_CYC - 1);

    typedef struct packed {
        logic             ff1;
        logic             ff2;
        logic             prev;
        logic [CNT_W-1:0] per_cnt;
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] idle_cnt;
        logic             have_first;
        logic [RUN_W-1:0] run;
        logic             last_cand;
        logic             pol_neg;
        logic             pol_valid;
        logic             active;
        logic             rise_stb;
        logic             per_stb;
        logic [CNT_W-1:0] period;
        logic             out;
    } meter_t;

    meter_t q, d;
    logic rise;
    logic cand;

    always_comb begin
        d        = q;
        d.ff1    = sync_in;
        d.ff2    = q.ff1;
        d.prev   = q.ff2;
        rise     = q.ff2 & ~q.prev;
        cand     = ({q.hi_cnt, 1'b0} >= {1'b0, q.per_cnt});
        d.rise_stb = rise;
        d.per_stb  = 1'b0;
        d.out      = q.ff2 ^ q.pol_neg;
        if (rise) begin
            d.per_cnt    = CNT_W'(1);
            d.hi_cnt     = CNT_W'(1);
            d.idle_cnt   = '0;
            d.active     = 1'b1;
            d.have_first = 1'b1;
            if (q.have_first) begin
                d.per_stb   = 1'b1;
                d.period    = q.per_cnt;
                d.last_cand = cand;
                if (q.run != '0 && cand == q.last_cand) begin
                    if (q.run != RUNS_L) begin
                        d.run = q.run + RUN_W'(1);
                    end
                end else begin
                    d.run = RUN_W'(1);
                end
                if (d.run == RUNS_L) begin
                    d.pol_neg   = cand;
                    d.pol_valid = 1'b1;
                end
            end
        end else begin
            if (q.per_cnt != '1) begin
                d.per_cnt = q.per_cnt + CNT_W'(1);
            end
            if (q.ff2 && q.hi_cnt != '1) begin
                d.hi_cnt = q.hi_cnt + CNT_W'(1);
            end
            if (q.idle_cnt != '1) begin
                d.idle_cnt = q.idle_cnt + CNT_W'(1);
            end
            if (q.idle_cnt >= LOST_LIM) begin
                d.active     = 1'b0;
                d.have_first = 1'b0;
                d.run        = '0;
                d.pol_valid  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_pos = q.out;
    assign active    = q.active;
    assign pol_valid = q.pol_valid;
    assign pol_neg   = q.pol_neg;
    assign rise_stb  = q.rise_stb;
    assign per_stb   = q.per_stb;
    assign period    = q.period;

endmodule

// File: rtl/smc_freq_judge.sv
module smc_freq_judge #(
    parameter int CNT_W      = 22,
    parameter int H_FAST_MAX = 1754,
    parameter int H_SLOW_MIN = 1818
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             per_stb,
    input  logic [CNT_W-1:0] period,
    output logic             fast,
    output logic             valid,
    output logic             stb
);
    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(H_FAST_MAX);
    localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(H_SLOW_MIN);

    typedef struct packed {
        logic fast;
        logic valid;
        logic stb;
    } judge_t;

    judge_t q, d;

    always_comb begin
        d     = q;
        d.stb = per_stb;
        if (!active) begin
            d.fast  = 1'b0;
            d.valid = 1'b0;
        end else if (per_stb) begin
            d.valid = 1'b1;
            if (period <= FAST_L) begin
                d.fast = 1'b1;
            end else if (period >= SLOW_L) begin
                d.fast = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fast  = q.fast;
    assign valid = q.valid;
    assign stb   = q.stb;

endmodule

// File: rtl/smc_mode_decide.sv
module smc_mode_decide
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       judge_stb,
    input  logic       fast,
    input  logic       fast_ok,
    input  logic       h_active,
    input  logic       h_ok,
    input  logic       h_neg,
    input  logic       v_active,
    input  logic       v_ok,
    input  logic       v_neg,
    output logic [3:0] mode_oh,
    output logic       no_signal
);
    typedef struct packed {
        cls_e mode;
        cls_e last;
        logic nosig;
    } decide_t;

    decide_t q, d;
    cls_e cand;

    always_comb begin
        d       = q;
        d.nosig = ~h_active;
        cand    = classify(fast_ok, fast, h_ok, h_neg, v_active & v_ok, v_neg);
        if (!h_active) begin
            d.mode = CLS_NONE;
            d.last = CLS_NONE;
        end else if (judge_stb) begin
            if (cand == q.last) begin
                d.mode = cand;
            end
            d.last = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode  <= CLS_NONE;
            q.last  <= CLS_NONE;
            q.nosig <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mode_oh   = cls_onehot(q.mode);
    assign no_signal = q.nosig;

endmodule

// File: rtl/sync_mode_classifier.sv
module sync_mode_classifier #(
    parameter int CNT_W      = 22,
    parameter int H_LOST_CYC = 5000,
    parameter int V_LOST_CYC = 2500000,
    parameter int POL_RUNS   = 3,
    parameter int H_FAST_MAX = 1754,
    parameter int H_SLOW_MIN = 1818
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_in,
    input  logic       vsync_in,
    output logic [3:0] mode_oh,
    output logic       no_signal,
    output logic       hsync_out,
    output logic       vsync_out
);
    localparam int NCH = 2;  // channel 0 horizontal, channel 1 vertical

    logic [NCH-1:0] sync_vec;
    logic [NCH-1:0] lvl_vec;
    logic [NCH-1:0] act_vec;
    logic [NCH-1:0] pvld_vec;
    logic [NCH-1:0] pneg_vec;
    logic [NCH-1:0] rise_vec;
    logic [NCH-1:0] pstb_vec;
    logic [CNT_W-1:0] per_arr [NCH];

    logic h_fast;
    logic h_fast_ok;
    logic judge_stb;

    assign sync_vec = {vsync_in, hsync_in};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_meter
        smc_sync_meter #(
            .CNT_W   (CNT_W),
            .LOST_CYC(ch == 0 ? H_LOST_CYC : V_LOST_CYC),
            .POL_RUNS(POL_RUNS)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_vec[ch]),
            .level_pos(lvl_vec[ch]),
            .active   (act_vec[ch]),
            .pol_valid(pvld_vec[ch]),
            .pol_neg  (pneg_vec[ch]),
            .rise_stb (rise_vec[ch]),
            .per_stb  (pstb_vec[ch]),
            .period   (per_arr[ch])
        );
    end

    smc_freq_judge #(
        .CNT_W     (CNT_W),
        .H_FAST_MAX(H_FAST_MAX),
        .H_SLOW_MIN(H_SLOW_MIN)
    ) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (act_vec[0]),
        .per_stb(pstb_vec[0]),
        .period (per_arr[0]),
        .fast   (h_fast),
        .valid  (h_fast_ok),
        .stb    (judge_stb)
    );

    smc_mode_decide u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .judge_stb(judge_stb),
        .fast     (h_fast),
        .fast_ok  (h_fast_ok),
        .h_active (act_vec[0]),
        .h_ok     (pvld_vec[0]),
        .h_neg    (pneg_vec[0]),
        .v_active (act_vec[1]),
        .v_ok     (pvld_vec[1]),
        .v_neg    (pneg_vec[1]),
        .mode_oh  (mode_oh),
        .no_signal(no_signal)
    );

    assign hsync_out = lvl_vec[0];
    assign vsync_out = lvl_vec[1];

endmodule

// File: rtl/smc_checker.sv
module smc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_oh,
    input logic       no_signal,
    input logic       judge_stb,
    input logic       h_rise
);
    // R11: never more than one flag
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_oh));

    // R8: no mode while the line sync is missing
    p_nosig_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_signal |-> (mode_oh == 4'b0000));

    // R11: the mode moves only after a line measurement or on loss
    p_mode_on_meas_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_oh) |-> ($past(judge_stb) || no_signal));

    // R8: signal presence returns only after a line rising edge
    p_nosig_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_signal) |-> $past(h_rise));

endmodule

bind sync_mode_classifier smc_checker u_smc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_oh  (mode_oh),
    .no_signal(no_signal),
    .judge_stb(judge_stb),
    .h_rise   (rise_vec[0])
);

// File: tb/sync_mode_classifier_bench.sv
module sync_mode_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [7:0] hper;
        logic [7:0] hpw;
        logic       hneg;
        logic [9:0] vper;
        logic [7:0] vpw;
        logic       vneg;
        logic       ven;
        logic [3:0] exp_oh;
        logic [3:0] req;
    } vec_t;

    // Walked in order; state carries between rows (hysteresis rows rely on it).
    localparam vec_t VECS [NV] = '{
        '{8'd40, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b1, 4'b0001, 4'd1},  // R1
        '{8'd40, 8'd4, 1'b1, 10'd400, 8'd8, 1'b0, 1'b1, 4'b0010, 4'd2},  // R2
        '{8'd40, 8'd4, 1'b0, 10'd400, 8'd8, 1'b1, 1'b1, 4'b0100, 4'd3},  // R3
        '{8'd40, 8'd4, 1'b0, 10'd400, 8'd8, 1'b0, 1'b1, 4'b0000, 4'd4},  // R4
        '{8'd40, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b0, 4'b0000, 4'd7},  // R7
        '{8'd60, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b1, 4'b1000, 4'd5},  // R5
        '{8'd48, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b1, 4'b1000, 4'd6},  // R6 holds slow
        '{8'd60, 8'd4, 1'b0, 10'd400, 8'd8, 1'b0, 1'b1, 4'b1000, 4'd5},  // R5
        '{8'd40, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b1, 4'b0001, 4'd1},  // R1
        '{8'd48, 8'd4, 1'b1, 10'd400, 8'd8, 1'b1, 1'b1, 4'b0001, 4'd6}   // R6 holds fast
    };

    logic clk = 1'b0;
    logic rst_n;
    logic hsync_in, vsync_in;
    logic [3:0] mode_oh;
    logic no_signal, hsync_out, vsync_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int h_per = 40, h_pw = 4, v_per = 400, v_pw = 8;
    bit h_neg = 1'b0, v_neg = 1'b0, h_en = 1'b0, v_en = 1'b0;
    logic [2:0] h_hist = '0, v_hist = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_mode_classifier #(
        .CNT_W(12), .H_LOST_CYC(64), .V_LOST_CYC(1000),
        .POL_RUNS(3), .H_FAST_MAX(45), .H_SLOW_MIN(50)
    ) u_sync_mode_classifier (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .mode_oh(mode_oh), .no_signal(no_signal),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    initial begin
        int cnt = 0;
        logic p;
        hsync_in = 1'b0;
        forever begin
            @(negedge clk);
            if (h_en) begin
                p = (cnt < h_pw);
                hsync_in = p ^ h_neg;
                cnt = (cnt + 1 >= h_per) ? 0 : cnt + 1;
            end else begin
                p = 1'b0;
                hsync_in = h_neg;
                cnt = 0;
            end
            h_hist = {h_hist[1:0], p};
        end
    end

    initial begin
        int cnt = 0;
        logic p;
        vsync_in = 1'b0;
        forever begin
            @(negedge clk);
            if (v_en) begin
                p = (cnt < v_pw);
                vsync_in = p ^ v_neg;
                cnt = (cnt + 1 >= v_per) ? 0 : cnt + 1;
            end else begin
                p = 1'b0;
                vsync_in = v_neg;
                cnt = 0;
            end
            v_hist = {v_hist[1:0], p};
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R9 R10: regenerated syncs follow the high-going pulse, 3 cycles late
    task automatic check_norm(input bit do_v);
        int hbad = 0;
        int vbad = 0;
        for (int i = 0; i < 400; i++) begin
            step(1);
            if (hsync_out !== h_hist[2]) hbad++;
            if (vsync_out !== v_hist[2]) vbad++;
        end
        check(hbad == 0, "R9 hsync_out", hbad, 0);
        if (do_v) check(vbad == 0, "R10 vsync_out", vbad, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        step(5);
        check(mode_oh == 4'b0000, "R8 reset mode", mode_oh, 0);
        check(no_signal == 1'b1, "R8 reset no_signal", no_signal, 1);
        rst_n = 1'b1;
        step(20);
        check(no_signal == 1'b1, "R8 idle no_signal", no_signal, 1);
        check(mode_oh == 4'b0000, "R8 idle mode", mode_oh, 0);

        for (int k = 0; k < NV; k++) begin
            h_per = int'(VECS[k].hper);
            h_pw  = int'(VECS[k].hpw);
            h_neg = VECS[k].hneg;
            v_per = int'(VECS[k].vper);
            v_pw  = int'(VECS[k].vpw);
            v_neg = VECS[k].vneg;
            v_en  = VECS[k].ven;
            h_en  = 1'b1;
            step(3000);
            check(mode_oh == VECS[k].exp_oh,
                  $sformatf("R%0d vector %0d mode", VECS[k].req, k),
                  mode_oh, VECS[k].exp_oh);
            check(no_signal == 1'b0, "R8 present", no_signal, 0);
            check_norm(VECS[k].ven);
        end

        // R8: line sync stops
        h_en = 1'b0;
        step(100);
        check(no_signal == 1'b1, "R8 loss no_signal", no_signal, 1);
        check(mode_oh == 4'b0000, "R8 loss mode", mode_oh, 0);

        // R11: resume; edge 4 gives first valid class, edge 5 confirms it
        h_per = 40; h_pw = 4; h_neg = 1'b1;
        h_en = 1'b1;
        step(150);
        check(no_signal == 1'b0, "R8 resume no_signal", no_signal, 0);
        check(mode_oh == 4'b0000, "R11 one measurement", mode_oh, 0);
        step(40);
        check(mode_oh == 4'b0001, "R11 two measurements", mode_oh, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule